// File: doc/BRIEF.md
# Triggered One-Shot Pulse Timer

This block counts ticks of a count-enable input and, once started, drives one delayed pulse onto its output pins. A start comes from a software write or from a selected edge on an asynchronous trigger input. Two compare values set the shape of the pulse. The delay value gives the number of ticks from the start to the first active tick. The end value gives the count at which the pulse finishes. After the end count the counter clears to zero and waits for the next start.

Software uses one write/read port to reach four locations: end compare, delay compare, control, and a read-only copy of the live counter. Each output pin can be switched between carrying the pulse and holding a fixed level. Its polarity can be chosen.

Top module: `oneshot_pulse_timer`

## Requirements
- R1: Address 0 holds the end compare, address 1 the delay compare, address 2 the control word and address 3 the counter. Address 3 is read-only, and writes to it have no effect. Control bit 0 is run and bit 1 is a start strobe that always reads back 0. Bits 3:2 hold the edge select. For pin k, bit 4+3k is enable, bit 5+3k is the disabled level and bit 6+3k is polarity. Read data is combinational on the read address.
- R2: A write to control with bit 1 set starts a one-shot if the written run bit is 1 and no one-shot is in progress. The counter then reads 0 on the next cycle and advances by one on each cycle where the tick input is high.
- R3: The number of ticks from the start to the first cycle with the pulse active equals the delay compare value.
- R4: The pulse stays active for exactly (end − delay + 1) ticks. The tick consumed at the end count returns the counter to 0 and stops it.
- R5: A pin's polarity bit of 0 makes the pulse high on the pin, and 1 makes it low. When a pin is enabled and no pulse is present, it shows the opposite of its active level.
- R6: A pin with its enable bit at 0 holds its disabled-level bit (0 low, 1 high) for the whole one-shot.
- R7: The trigger input passes through two synchronising flip-flops before edge detection. The edge select codes are 00 none, 01 rising, 10 falling and 11 both. A selected edge starts a one-shot under the same conditions as the start strobe.
- R8: Software starts and trigger edges that arrive during a one-shot are ignored. They change neither the timing of the pulse nor cause a second pulse afterwards.
- R9: If the delay compare exceeds the end compare, no pulse appears. The counter still runs up to the end value, then clears and stops.
- R10: Writing run = 0 stops the counter on that edge and sets it to 0. The pins return to their inactive level on that edge, and the counter stays at 0 while run is 0.
- R11: After reset every register and the counter are 0, and all pins drive low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_tick | input | 1 | Count enable; one tick per high cycle |
| trig_in | input | 1 | Asynchronous external trigger |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CNT_W | Register read data |
| pin_out | output | N_PINS | Pulse output pins |

## Verification
A miscounted or stuck counter shows up on the counter readback on the very next cycle. It also shows up at the pins as a delay or width that is off by whole ticks, which is visible once the one-shot ends. A state machine that does not return to idle, or that accepts a start while busy, shows up as a pulse whose timing is stretched, or as an unrequested second pulse within a few cycles of the first. A wrong edge decode or polarity bit is visible on a pin within three cycles of the trigger edge or the control write.

// File: rtl/ospt_pkg.sv
package ospt_pkg;

  typedef enum logic [1:0] {
    REG_CMP_END = 2'd0,
    REG_CMP_DLY = 2'd1,
    REG_CTRL    = 2'd2,
    REG_COUNT   = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

  localparam int CTRL_RUN      = 0;
  localparam int CTRL_START    = 1;
  localparam int CTRL_EDGE_LO  = 2;
  localparam int CTRL_PIN_BASE = 4;
  localparam int PIN_FIELD_W   = 3;

  function automatic logic edge_hit(input logic [1:0] sel, input logic cur, input logic prev);
    case (sel)
      EDGE_RISE: return cur & ~prev;
      EDGE_FALL: return ~cur & prev;
      EDGE_BOTH: return cur ^ prev;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic pin_drive(input logic pulse, input logic en,
                                     input logic lvl, input logic pol);
    return en ? (pulse ^ pol) : lvl;
  endfunction

endpackage

// File: rtl/ospt_regs.sv
module ospt_regs
  import ospt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_PINS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  cmp_end,
  output logic [CNT_W-1:0]  cmp_dly,
  output logic              run_q,
  output logic              run_eff,
  output logic              sw_start,
  output logic [1:0]        edge_sel,
  output logic [N_PINS-1:0] pin_en,
  output logic [N_PINS-1:0] pin_lvl,
  output logic [N_PINS-1:0] pin_pol,
  output logic [CNT_W-1:0]  ctrl_rd
);
  localparam int CTRL_W = CTRL_PIN_BASE + PIN_FIELD_W * N_PINS;

  logic [CTRL_W-1:0] ctrl_q;
  logic              ctrl_wr;

  assign ctrl_wr = wr_en && (wr_addr == REG_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_end <= '0;
      cmp_dly <= '0;
      ctrl_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == REG_CMP_END) cmp_end <= wr_data;
      if (wr_addr == REG_CMP_DLY) cmp_dly <= wr_data;
      if (ctrl_wr) begin
        ctrl_q             <= wr_data[CTRL_W-1:0];
        ctrl_q[CTRL_START] <= 1'b0;
      end
    end
  end

  assign run_q    = ctrl_q[CTRL_RUN];
  assign run_eff  = ctrl_wr ? wr_data[CTRL_RUN] : ctrl_q[CTRL_RUN];
  assign sw_start = ctrl_wr && wr_data[CTRL_START];
  assign edge_sel = ctrl_q[CTRL_EDGE_LO +: 2];
  assign ctrl_rd  = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};

  for (genvar k = 0; k < N_PINS; k++) begin : g_pin_fields
    assign pin_en[k]  = ctrl_q[CTRL_PIN_BASE + PIN_FIELD_W*k];
    assign pin_lvl[k] = ctrl_q[CTRL_PIN_BASE + PIN_FIELD_W*k + 1];
    assign pin_pol[k] = ctrl_q[CTRL_PIN_BASE + PIN_FIELD_W*k + 2];
  end

endmodule

// File: rtl/ospt_trig_sync.sv
module ospt_trig_sync
  import ospt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_in,
  input  logic [1:0] edge_sel,
  output logic       trig_evt
);
  logic [SYNC_STAGES:0] shreg;
  logic                 cur;
  logic                 prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[SYNC_STAGES-1:0], trig_in};
  end

  assign cur      = shreg[SYNC_STAGES-1];
  assign prev     = shreg[SYNC_STAGES];
  assign trig_evt = edge_hit(edge_sel, cur, prev);

endmodule

// File: rtl/ospt_counter.sv
module ospt_counter
  import ospt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run_eff,
  input  logic             trig,
  input  logic [CNT_W-1:0] cmp_end,
  input  logic [CNT_W-1:0] cmp_dly,
  output logic [CNT_W-1:0] cnt,
  output logic             busy,
  output logic             pulse
);
  run_state_e state;
  logic       at_end;

  function automatic logic in_window(input logic [CNT_W-1:0] c,
                                     input logic [CNT_W-1:0] lo,
                                     input logic [CNT_W-1:0] hi);
    return (lo <= hi) && (c >= lo) && (c <= hi);
  endfunction

  assign at_end = (cnt >= cmp_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (!run_eff) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (trig) begin
          state <= ST_RUN;
          cnt   <= '0;
        end
        ST_RUN: if (tick) begin
          if (at_end) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (state == ST_RUN);
  assign pulse = busy && in_window(cnt, cmp_dly, cmp_end);

  AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cnt == '0)); // R4
  AST_START_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cnt == '0)); // R2
  AST_RUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1)); // R8

endmodule

// File: rtl/ospt_pin.sv
module ospt_pin
  import ospt_pkg::*;
(
  input  logic pulse,
  input  logic en,
  input  logic lvl,
  input  logic pol,
  output logic pin
);
  assign pin = pin_drive(pulse, en, lvl, pol);
endmodule

// File: rtl/oneshot_pulse_timer.sv
module oneshot_pulse_timer
  import ospt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int N_PINS      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_tick,
  input  logic              trig_in,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [1:0]        rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [N_PINS-1:0] pin_out
);
  logic [CNT_W-1:0]  cmp_end, cmp_dly, ctrl_rd, cnt;
  logic              run_q, run_eff, sw_start, ext_evt, busy, pulse, start_req;
  logic [1:0]        edge_sel;
  logic [N_PINS-1:0] pin_en, pin_lvl, pin_pol;

  ospt_regs #(.CNT_W(CNT_W), .N_PINS(N_PINS)) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .cmp_end, .cmp_dly, .run_q, .run_eff, .sw_start, .edge_sel,
    .pin_en, .pin_lvl, .pin_pol, .ctrl_rd
  );

  ospt_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .trig_in, .edge_sel, .trig_evt(ext_evt)
  );

  assign start_req = sw_start || ext_evt;

  ospt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk, .rst_n, .tick(cnt_tick), .run_eff, .trig(start_req),
    .cmp_end, .cmp_dly, .cnt, .busy, .pulse
  );

  for (genvar k = 0; k < N_PINS; k++) begin : g_pins
    ospt_pin u_pin (
      .pulse(pulse), .en(pin_en[k]), .lvl(pin_lvl[k]), .pol(pin_pol[k]), .pin(pin_out[k])
    );
  end

  always_comb begin
    case (rd_addr)
      REG_CMP_END: rd_data = cmp_end;
      REG_CMP_DLY: rd_data = cmp_dly;
      REG_CTRL:    rd_data = ctrl_rd;
      default:     rd_data = cnt;
    endcase
  end

  AST_STOP_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> (!busy && cnt == '0)); // R10
  AST_PULSE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> run_q); // R10

endmodule

// File: tb/sim_oneshot_pulse_timer.sv
module sim_oneshot_pulse_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_tick = 1'b0;
  logic        trig_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  pin_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  localparam logic [15:0] B_RUN   = 16'h0001;
  localparam logic [15:0] B_START = 16'h0002;
  localparam logic [15:0] B_BOTH  = 16'h000C;
  localparam logic [15:0] PINCFG  = 16'h0290;

  always #10 clk = ~clk;

  oneshot_pulse_timer u0 (
    .clk, .rst_n, .cnt_tick, .trig_in, .wr_en, .wr_addr, .wr_data,
    .rd_addr, .rd_data, .pin_out
  );

  function automatic int exp_width(input int d0, input int d1);
    if (d1 > d0) return 0;
    return d0 - d1 + 1;
  endfunction

  function automatic logic exp_pin(input logic p, input logic en, input logic lvl, input logic pol);
    if (!en) return lvl;
    return pol ? ~p : p;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic shot(input int d0, input int d1, input int pct, input bit poke);
    int dt = 0, wt = 0, tt = 0, rmax = 0, guard = 0;
    bit seen = 0, polbad = 0, poked = 0, act;
    cnt_tick = 1'b0;
    wr(2'd0, 16'(d0));
    wr(2'd1, 16'(d1));
    rd_addr = 2'd3;
    wr(2'd2, B_RUN | B_START | B_BOTH | PINCFG);
    while (tt < d0 + 1 && guard < 20000) begin
      guard++;
      act = pin_out[0];
      if (pin_out[1] !== exp_pin(act, 1'b1, 1'b0, 1'b1)) polbad = 1;
      if (int'(rd_data) > rmax) rmax = int'(rd_data);
      if (act) seen = 1;
      cnt_tick = (($urandom % 100) < pct);
      if (act) wt += int'(cnt_tick);
      else if (!seen) dt += int'(cnt_tick);
      tt += int'(cnt_tick);
      if (poke && !poked && tt >= d0 / 2) begin
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = B_RUN | B_START | B_BOTH | PINCFG;
        trig_in = ~trig_in;
        poked = 1;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    cnt_tick = 1'b0;
    chk(pin_out[0] == 1'b0, "R4 pin inactive after end", pin_out[0], 0);
    chk(rd_data == 16'd0, "R4 counter cleared after end", rd_data, 0);
    chk(rmax == d0, "R9 counter peak equals end compare", rmax, d0);
    chk(!polbad, "R5 inverted pin mirrors pulse", polbad, 0);
    if (d1 <= d0) begin
      chk(dt == d1, "R3 delay ticks", dt, d1);
      chk(wt == exp_width(d0, d1), "R4 width ticks", wt, exp_width(d0, d1));
    end else begin
      chk(!seen, "R9 no pulse when delay exceeds end", seen, 0);
    end
    cnt_tick = 1'b1;
    seen = 0;
    repeat (6) begin
      @(negedge clk);
      if (pin_out[0] || rd_data != 0) seen = 1;
    end
    cnt_tick = 1'b0;
    chk(!seen, "R8 no restart after ignored triggers", seen, 0);
  endtask

  task automatic edge_try(input logic [1:0] sel, input logic from, input bit expect_pulse);
    bit seen = 0;
    cnt_tick = 1'b0;
    wr(2'd2, B_RUN | PINCFG);
    trig_in = from;
    repeat (5) @(negedge clk);
    wr(2'd0, 16'd3);
    wr(2'd1, 16'd1);
    wr(2'd2, B_RUN | {12'd0, sel, 2'b00} | PINCFG);
    cnt_tick = 1'b1;
    trig_in = ~from;
    repeat (14) begin
      @(negedge clk);
      if (pin_out[0]) seen = 1;
    end
    cnt_tick = 1'b0;
    chk(seen == expect_pulse, $sformatf("R7 edge sel=%0d from=%0d", sel, from), seen, expect_pulse);
  endtask

  initial begin
    bit bad;
    void'($urandom(32'd20241));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pin_out == 2'b00, "R11 pins low after reset", pin_out, 0);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #1;
      chk(rd_data == 16'd0, $sformatf("R11 reg %0d zero after reset", a), rd_data, 0);
    end

    // R1 register readback
    wr(2'd0, 16'hA5C3);
    wr(2'd1, 16'h1234);
    wr(2'd2, 16'h03FE);
    rd_addr = 2'd0; #1; chk(rd_data == 16'hA5C3, "R1 end compare readback", rd_data, 16'hA5C3);
    rd_addr = 2'd1; #1; chk(rd_data == 16'h1234, "R1 delay compare readback", rd_data, 16'h1234);
    rd_addr = 2'd2; #1; chk(rd_data == 16'h03FC, "R1 control readback start reads 0", rd_data, 16'h03FC);
    wr(2'd3, 16'h0055);
    rd_addr = 2'd3; #1; chk(rd_data == 16'h0000, "R1 counter write ignored", rd_data, 0);
    wr(2'd2, 16'h0000);

    // R2 counter steps with full-rate ticks
    wr(2'd0, 16'd20);
    wr(2'd1, 16'd30);
    rd_addr = 2'd3;
    wr(2'd2, B_RUN | B_START | PINCFG);
    chk(rd_data == 16'd0, "R2 counter zero after start", rd_data, 0);
    cnt_tick = 1'b1;
    repeat (5) @(negedge clk);
    chk(rd_data == 16'd5, "R2 counter after five ticks", rd_data, 5);
    cnt_tick = 1'b0;
    repeat (3) @(negedge clk);
    chk(rd_data == 16'd5, "R2 counter holds without tick", rd_data, 5);
    cnt_tick = 1'b1;
    repeat (20) @(negedge clk);
    cnt_tick = 1'b0;

    // directed corners
    shot(0, 0, 100, 0);
    shot(5, 5, 100, 0);
    shot(10, 0, 60, 1);
    shot(3, 7, 100, 0);
    shot(12, 4, 40, 1);

    // constrained random shots
    for (int i = 0; i < 24; i++) begin
      int d0 = $urandom % 41;
      int d1 = $urandom % 45;
      int pct = 25 + ($urandom % 76);
      shot(d0, d1, pct, (d0 >= 8) && ($urandom % 2 == 1));
    end

    // R6 disabled pins hold their level
    wr(2'd0, 16'd6);
    wr(2'd1, 16'd2);
    cnt_tick = 1'b1;
    wr(2'd2, B_RUN | B_START | 16'h0220);
    bad = 0;
    repeat (10) begin
      if (pin_out[0] !== exp_pin(1'b1, 1'b0, 1'b1, 1'b0)) bad = 1;
      if (pin_out[1] !== exp_pin(1'b1, 1'b0, 1'b0, 1'b1)) bad = 1;
      @(negedge clk);
    end
    chk(!bad, "R6 disabled pins hold level", bad, 0);
    cnt_tick = 1'b0;

    // R10 run clear mid-pulse
    wr(2'd0, 16'd40);
    wr(2'd1, 16'd5);
    rd_addr = 2'd3;
    cnt_tick = 1'b1;
    wr(2'd2, B_RUN | B_START | PINCFG);
    repeat (10) @(negedge clk);
    chk(pin_out == 2'b01, "R5 pins active mid-run", pin_out, 1);
    wr(2'd2, PINCFG);
    chk(pin_out == 2'b10, "R10 pins inactive after clear", pin_out, 2);
    chk(rd_data == 16'd0, "R10 counter zero after clear", rd_data, 0);
    repeat (5) @(negedge clk);
    chk(rd_data == 16'd0, "R10 counter stays zero", rd_data, 0);
    wr(2'd2, B_RUN | PINCFG);
    repeat (5) @(negedge clk);
    chk(rd_data == 16'd0 && pin_out == 2'b10, "R10 no resume without start", rd_data, 0);
    cnt_tick = 1'b0;

    // R7 edge selection
    edge_try(2'b01, 1'b0, 1'b1);
    edge_try(2'b01, 1'b1, 1'b0);
    edge_try(2'b10, 1'b1, 1'b1);
    edge_try(2'b10, 1'b0, 1'b0);
    edge_try(2'b11, 1'b0, 1'b1);
    edge_try(2'b11, 1'b1, 1'b1);
    edge_try(2'b00, 1'b0, 1'b0);
    edge_try(2'b00, 1'b1, 1'b0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule